// File: doc/BRIEF.md
# Compare-and-Rollover General Timer

This block is an up-counting timer with a single compare channel and a wrap detector, set up and observed through a small word-indexed register port. Software loads a compare value and an interrupt mask, then enables counting. The counter advances by one on every clock cycle in which the tick-enable input is high. Two sticky status flags record two events: the counter landing on the compare value, and the counter wrapping from all-ones to zero. Software clears a flag by writing a one to its bit. One level interrupt line reports any unmasked flag, but only while the timer is enabled.

Two control bits shape the count sequence. The first picks whether the counter is zeroed when the timer is switched on. The second picks restart mode, where the counter drops back to zero after hitting the compare value, or free-run mode, where it keeps going to all-ones. A control write with the reset bit set returns the working registers to zero in a single cycle. The register port has no stream traffic, so it has no valid/ready handshake. Writes are plain strobes that take effect at the next clock edge, and reads are combinational from the selected index.

Top module: `gp_cmp_timer`

## Requirements
- R1: After reset, every register index reads zero and `irq` is low.
- R2: A write lands at the next clock edge. Index 0 (control), 1 (prescaler), 3 (interrupt mask) and 4 (compare, CNT_W bits) read back what was written. Control bits 2 to 9 and 16 to 31 are stored but have no effect, apart from bits 0, 1 and 9 described below. Index 9 reads the counter. Every other index reads zero.
- R3: While control bit 0 (enable) is set, the counter rises by one on each cycle in which `tick_en` is high. It holds its value when `tick_en` is low or the timer is disabled.
- R4: A control write that takes bit 0 from 0 to 1 while bit 1 is set zeroes the counter. With bit 1 clear, the counter keeps its value.
- R5: Status bit 0 is set when the counter advances onto the compare value.
- R6: With control bit 9 clear (restart), a counter that equals the compare value goes to zero on its next advance. With bit 9 set (free-run), it keeps incrementing.
- R7: Status bit 5 is set when the counter advances from all-ones, and the counter becomes zero.
- R8: Writing index 2 clears each status bit written as 1. Bits written as 0 are left unchanged.
- R9: If a flag's event and a clearing write to that flag fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when enable is set and (status bit 0 and mask bit 0) or (status bit 5 and mask bit 5).
- R11: A control write with bit 15 set zeroes the counter, status, prescaler, mask and compare registers. It stores the written control word with bits 0, 2, 3, 4 and 15 cleared. This takes priority over any count or flag event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick qualifier |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Word index of the read |
| rd_data | output | 32 | Read data for `rd_idx` |
| irq | output | 1 | Level interrupt |

## Verification
The two functions that can fall in the same cycle are flag setting and flag clearing. The bench provokes this overlap by putting a write-one-to-clear status write on the exact tick that wraps the counter from all-ones. In that same write, the compare flag is cleared while its event is absent. The expected result is the rollover flag set and the compare flag clear. A second overlap is a software reset issued on an active count tick, where the counter and flags must read zero afterwards.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  typedef logic [IDX_W-1:0] idx_t;

  // register word indices
  localparam idx_t IDX_CTRL = 4'd0;
  localparam idx_t IDX_PRE  = 4'd1;
  localparam idx_t IDX_STAT = 4'd2;
  localparam idx_t IDX_MASK = 4'd3;
  localparam idx_t IDX_CMP  = 4'd4;
  localparam idx_t IDX_CNT  = 4'd9;

  // control bits with behaviour
  localparam int B_EN      = 0;
  localparam int B_ZERO_ON = 1;
  localparam int B_DBG     = 2;
  localparam int B_WAIT    = 3;
  localparam int B_DOZE    = 4;
  localparam int B_FREERUN = 9;
  localparam int B_SWR     = 15;

  // status / mask bit positions
  localparam int F_CMP = 0;
  localparam int F_ROV = 5;

  localparam logic [DATA_W-1:0] SWR_DROP =
    (DATA_W'(1) << B_EN)   | (DATA_W'(1) << B_DBG) | (DATA_W'(1) << B_WAIT) |
    (DATA_W'(1) << B_DOZE) | (DATA_W'(1) << B_SWR);
endpackage

// File: rtl/gpt_ctrl_regs.sv
module gpt_ctrl_regs
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  idx_t              wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] pre_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              swr,
  output logic              zero_req,
  output logic              stat_wr
);
  logic ctrl_wr;
  logic en_rise_zero;

  assign ctrl_wr      = wr_en && (wr_idx == IDX_CTRL);
  assign swr          = ctrl_wr && wr_data[B_SWR];
  assign en_rise_zero = ctrl_wr && !wr_data[B_SWR] && !ctrl_q[B_EN] &&
                        wr_data[B_EN] && wr_data[B_ZERO_ON];
  assign zero_req     = swr || en_rise_zero;
  assign stat_wr      = wr_en && (wr_idx == IDX_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (swr) begin
      ctrl_q <= wr_data & ~SWR_DROP;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || swr) begin
      pre_q  <= '0;
      mask_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_PRE)  pre_q  <= wr_data;
      if (wr_idx == IDX_MASK) mask_q <= wr_data;
      if (wr_idx == IDX_CMP)  cmp_q  <= wr_data[CNT_W-1:0];
    end
  end

  AST_SWR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> !ctrl_q[B_EN]) else $error("swr left enable set"); // R11
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick_en,
  input  logic             restart,
  input  logic             zero_req,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cmp_evt,
  output logic             rov_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             adv;
  logic [CNT_W-1:0] nxt;

  assign adv     = en && tick_en;
  assign nxt     = (restart && (cnt_q == cmp)) ? '0 : cnt_q + CNT_W'(1);
  assign cmp_evt = adv && (nxt == cmp);
  assign rov_evt = adv && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || zero_req) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !zero_req) |=> $stable(cnt_q)) else $error("counter moved while idle"); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && restart && !zero_req && (cnt_q == cmp)) |=> (cnt_q == '0)) else $error("no restart"); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rov_evt && !zero_req) |=> (cnt_q == '0)) else $error("wrap not zero"); // R7
endmodule

// File: rtl/gpt_flags.sv
module gpt_flags
  import gpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmp_evt,
  input  logic              rov_evt,
  input  logic              en,
  input  logic [DATA_W-1:0] mask,
  output logic              cmp_flag,
  output logic              rov_flag,
  output logic              irq
);
  logic clr_cmp;
  logic clr_rov;

  assign clr_cmp = stat_wr && wr_data[F_CMP];
  assign clr_rov = stat_wr && wr_data[F_ROV];

  always_ff @(posedge clk) begin
    if (!rst_n || swr) begin
      cmp_flag <= 1'b0;
      rov_flag <= 1'b0;
    end else begin
      cmp_flag <= (cmp_flag && !clr_cmp) || cmp_evt;
      rov_flag <= (rov_flag && !clr_rov) || rov_evt;
    end
  end

  assign irq = en && ((cmp_flag && mask[F_CMP]) || (rov_flag && mask[F_ROV]));

  AST_CMP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && !swr) |=> cmp_flag) else $error("compare flag lost"); // R9
  AST_ROV_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rov_evt && !swr) |=> rov_flag) else $error("rollover flag lost"); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmp && !cmp_evt) |=> !cmp_flag) else $error("w1c failed"); // R8
endmodule

// File: rtl/gp_cmp_timer.sv
module gp_cmp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, pre_q, mask_q, stat_word;
  logic [CNT_W-1:0]  cmp_q, cnt_q;
  logic              swr, zero_req, stat_wr;
  logic              cmp_evt, rov_evt, cmp_flag, rov_flag;

  gpt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .pre_q(pre_q), .mask_q(mask_q), .cmp_q(cmp_q),
    .swr(swr), .zero_req(zero_req), .stat_wr(stat_wr)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_EN]), .tick_en(tick_en),
    .restart(!ctrl_q[B_FREERUN]), .zero_req(zero_req), .cmp(cmp_q),
    .cnt_q(cnt_q), .cmp_evt(cmp_evt), .rov_evt(rov_evt)
  );

  gpt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .swr(swr), .stat_wr(stat_wr), .wr_data(wr_data),
    .cmp_evt(cmp_evt), .rov_evt(rov_evt), .en(ctrl_q[B_EN]), .mask(mask_q),
    .cmp_flag(cmp_flag), .rov_flag(rov_flag), .irq(irq)
  );

  always_comb begin
    stat_word        = '0;
    stat_word[F_CMP] = cmp_flag;
    stat_word[F_ROV] = rov_flag;
  end

  always_comb begin
    unique case (rd_idx)
      IDX_CTRL: rd_data = ctrl_q;
      IDX_PRE:  rd_data = pre_q;
      IDX_STAT: rd_data = stat_word;
      IDX_MASK: rd_data = mask_q;
      IDX_CMP:  rd_data = DATA_W'(cmp_q);
      IDX_CNT:  rd_data = DATA_W'(cnt_q);
      default:  rd_data = '0;
    endcase
  end

  AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (cnt_q == '0 && !cmp_flag && !rov_flag && !irq)) else $error("swr incomplete"); // R11
  AST_ZERO_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_CTRL && !ctrl_q[B_EN] && wr_data[B_EN] && wr_data[B_ZERO_ON])
      |=> (cnt_q == '0)) else $error("enable did not zero"); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmp_flag || rov_flag)) else $error("irq without flag"); // R10
endmodule

// File: tb/sim_gp_cmp_timer.sv
module sim_gp_cmp_timer;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gp_cmp_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  widx;
    logic [31:0] wdat;
    logic        tk;
    logic [3:0]  ridx;
    logic [31:0] rexp;
    logic        iexp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd4, 32'd5,      1'b0, 4'd4, 32'd5,      1'b0, 4'd2},  // R2 compare
    '{1'b1, 4'd1, 32'hABCD,   1'b0, 4'd1, 32'hABCD,   1'b0, 4'd2},  // R2 prescaler
    '{1'b1, 4'd3, 32'h21,     1'b0, 4'd3, 32'h21,     1'b0, 4'd2},  // R2 mask
    '{1'b1, 4'd0, 32'h203,    1'b1, 4'd9, 32'd0,      1'b0, 4'd4},  // R4 enable, zero
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd1,      1'b0, 4'd3},  // R3
    '{1'b0, 4'd0, 32'd0,      1'b0, 4'd9, 32'd1,      1'b0, 4'd3},  // R3 no tick
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd2,      1'b0, 4'd3},
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd3,      1'b0, 4'd3},
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd2, 32'd0,      1'b0, 4'd5},  // R5 not yet
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd2, 32'd1,      1'b1, 4'd5},  // R5 hit at 5
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd6,      1'b1, 4'd6},  // R6 free-run
    '{1'b1, 4'd2, 32'd0,      1'b0, 4'd2, 32'd1,      1'b1, 4'd8},  // R8 zero keeps
    '{1'b1, 4'd2, 32'd1,      1'b0, 4'd2, 32'd0,      1'b0, 4'd8},  // R8 one clears
    '{1'b1, 4'd3, 32'd0,      1'b0, 4'd3, 32'd0,      1'b0, 4'd2},
    '{1'b1, 4'd0, 32'h1,      1'b1, 4'd9, 32'd7,      1'b0, 4'd3},  // R3 old mode counts
    '{1'b1, 4'd4, 32'd9,      1'b1, 4'd9, 32'd8,      1'b0, 4'd3},
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd2, 32'd1,      1'b0, 4'd10}, // R10 masked
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd0,      1'b0, 4'd6},  // R6 restart
    '{1'b1, 4'd3, 32'd1,      1'b0, 4'd3, 32'd1,      1'b1, 4'd10}, // R10 unmasked
    '{1'b1, 4'd0, 32'd0,      1'b1, 4'd9, 32'd1,      1'b0, 4'd10}, // R10 gated by enable
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd1,      1'b0, 4'd3},  // R3 disabled holds
    '{1'b1, 4'd0, 32'h201,    1'b0, 4'd9, 32'd1,      1'b1, 4'd4},  // R4 keep value
    '{1'b0, 4'd0, 32'd0,      1'b1, 4'd9, 32'd2,      1'b1, 4'd3},
    '{1'b1, 4'd0, 32'h200,    1'b0, 4'd9, 32'd2,      1'b0, 4'd3},
    '{1'b1, 4'd0, 32'h203,    1'b0, 4'd9, 32'd0,      1'b1, 4'd4},  // R4 zero again
    '{1'b0, 4'd0, 32'd0,      1'b0, 4'd7, 32'd0,      1'b1, 4'd2},  // R2 unmapped
    '{1'b0, 4'd0, 32'd0,      1'b0, 4'd0, 32'h203,    1'b1, 4'd2}   // R2 control
  };

  task automatic apply(input logic w, input logic [3:0] idx, input logic [31:0] d,
                       input logic tk);
    @(negedge clk);
    wr_en = w; wr_idx = idx; wr_data = d; tick_en = tk;
    @(posedge clk);
    #2;
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic check(input logic [3:0] idx, input logic [31:0] exp_d,
                       input logic exp_i, input string req);
    rd_idx = idx;
    #1;
    total++;
    if (rd_data !== exp_d || irq !== exp_i) begin
      bad++;
      $display("FAIL %s idx=%0d data=%h/%h irq=%b/%b (actual/expected)",
               req, idx, rd_data, exp_d, irq, exp_i);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 16; i++) check(4'(i), 32'd0, 1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      apply(TBL[v].wr, TBL[v].widx, TBL[v].wdat, TBL[v].tk);
      check(TBL[v].ridx, TBL[v].rexp, TBL[v].iexp, $sformatf("R%0d", TBL[v].req));
    end

    // R7 count up to all-ones in free-run
    for (int k = 0; k < 255; k++) apply(1'b0, 4'd0, 32'd0, 1'b1);
    check(4'd9, 32'd255, 1'b1, "R7");
    check(4'd2, 32'd1, 1'b1, "R7");
    // R9 wrap tick collides with a clear of both flags
    apply(1'b1, 4'd2, 32'h21, 1'b1);
    check(4'd2, 32'h20, 1'b0, "R9");
    check(4'd9, 32'd0, 1'b0, "R7");
    apply(1'b1, 4'd3, 32'h20, 1'b0);
    check(4'd3, 32'h20, 1'b1, "R10");
    apply(1'b1, 4'd2, 32'h20, 1'b0);
    check(4'd2, 32'd0, 1'b0, "R8");

    // R11 software reset on an active tick
    apply(1'b0, 4'd0, 32'd0, 1'b1);
    apply(1'b1, 4'd0, 32'h00F0_83DF, 1'b1);
    check(4'd0, 32'h00F0_03C2, 1'b0, "R11");
    check(4'd9, 32'd0, 1'b0, "R11");
    check(4'd1, 32'd0, 1'b0, "R11");
    check(4'd3, 32'd0, 1'b0, "R11");
    check(4'd4, 32'd0, 1'b0, "R11");
    check(4'd2, 32'd0, 1'b0, "R11");
    apply(1'b0, 4'd0, 32'd0, 1'b1);
    check(4'd9, 32'd0, 1'b0, "R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule